// File: doc/BRIEF.md
# Handshaked Peripheral DMA Channel

This block is one channel of a small DMA engine. Software programs a source address, a destination address, a count of transfer cycles and a control word through a simple register port. Setting the enable bit starts the channel. For each beat it reads one item from the source side and writes it to the destination side. The control word says, for each side, whether that side is the memory bus or the peripheral bus. The size code travels with every request so that the fabric can steer byte lanes.

Each address moves by a signed step of 0, 1, 2 or 4 after every beat. In burst mode one count unit covers four beats, so an address then advances four steps per count unit. Either side may be paced by a numbered request line. When the count runs out, the channel stops and raises a finish flag. A configuration that cannot be carried out raises an error flag instead. Each flag has its own interrupt enable.

Reads and writes leave the channel on valid/ready streams. A request keeps its valid signal high and its fields unchanged until it sees ready, unless software aborts the transfer. Only one request is outstanding at a time. The read response is taken only while rd_rsp_ready is high. Back-pressure on either stream stalls the sequencer and does not lose data.

Top module: `dma_ch_top`

## Requirements
- R1: After reset every register reads zero, irq is low and neither request stream is valid.
- R2: The channel decodes only its own 16-byte window, which starts at CH_INDEX*16. Within it, offset 0 is the source address, 4 the destination address, 8 the cycle count and 12 the control word. Accesses to any other window have no effect.
- R3: Each beat issues one read at the source address, then one write of the returned data to the destination address. Control bit 6 (source) and bit 7 (destination) are carried on rd_req_mem and wr_req_mem, with 1 meaning the memory bus and 0 the peripheral bus. Requests hold until accepted.
- R4: Source step code is bits 10:8 and destination step code bits 14:12. Code 000 holds the address, 001/010/011 add 1/2/4 per beat, and 101/110/111 subtract 1/2/4 per beat. With burst (bit 3) set, one count unit is four beats.
- R5: Width code bits 21:20 selects word (00), halfword (01) or byte (10). The code is driven on rd_req_size and wr_req_size.
- R6: The count (24 bits) drops by one after each completed count unit and reads back as the remaining units. When it reaches zero, enable (bit 0) clears and finish status (bit 1) sets.
- R7: irq is high when finish status and finish interrupt enable (bit 2) are both set, or when error status (bit 4) and error interrupt enable (bit 5) are both set.
- R8: Writing 0 to a status bit clears it. Writing 1 to a status bit never sets it.
- R9: The source line number is bits 27:24 and the destination line number bits 19:16. Line 0 means the side runs freely. A nonzero line n makes the channel wait for dreq[n] before each count unit, and dack[n] pulses for one clock after the unit's last write.
- R10: Width code 11, or a nonzero step code whose magnitude is not the width in bytes (this includes 100), sets error status and clears enable with no bus request.
- R11: Writing the control word with bit 0 at 0 while running stops the channel before its next request. Finish status is not set.
- R12: While enabled, writes to the address and count registers, and to the configuration fields of the control word, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | RA_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_req_mem | output | 1 | Read bus select (1 = memory) |
| rd_req_size | output | 2 | Width code |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Read data accepted |
| rd_rsp_data | input | DW | Read data |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | AW | Write address |
| wr_req_mem | output | 1 | Write bus select (1 = memory) |
| wr_req_size | output | 2 | Width code |
| wr_req_data | output | DW | Write data |
| dreq | input | NL | Request lines, index 0 unused |
| dack | output | NL | Grant pulses, index 0 unused |
| irq | output | 1 | Interrupt |

## Verification
The hardest situation to reach from the ports is a channel that has started a transfer but is parked in the middle of it. That state is needed to read the count back between units, to test the register lock, and to abort. The stimulus parks the channel by pointing a side at a request line that the bench holds low. It then releases the line until exactly one grant is seen, drops the line again and inspects the registers. The abort case parks the channel the same way, tries locked writes and a write to a neighbouring window, then clears enable and raises the line to show that nothing else moves.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int BURST_BEATS = 4;

  localparam int B_EN    = 0;
  localparam int B_FIN   = 1;
  localparam int B_FIE   = 2;
  localparam int B_BURST = 3;
  localparam int B_ERR   = 4;
  localparam int B_EIE   = 5;
  localparam int B_SMEM  = 6;
  localparam int B_DMEM  = 7;
  localparam int F_SSTEP = 8;
  localparam int F_DSTEP = 12;
  localparam int F_DLINE = 16;
  localparam int F_WID   = 20;
  localparam int F_SLINE = 24;

  localparam logic [31:0] CTRL_KEEP = 32'h0F3F_77FF;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RD, S_RSP, S_WR, S_ACK
  } seq_state_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] w);
    case (w)
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      2'b10:   return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] step_mag(input logic [2:0] c);
    case (c[1:0])
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic cfg_ok(input logic [1:0] w, input logic [2:0] s,
                                  input logic [2:0] d);
    logic [2:0] u;
    u = unit_bytes(w);
    if (u == 3'd0) return 1'b0;
    return ((s == 3'd0) || (step_mag(s) == u)) &&
           ((d == 3'd0) || (step_mag(d) == u));
  endfunction

  function automatic logic [31:0] step_delta(input logic [2:0] c);
    logic [31:0] m;
    m = {29'd0, step_mag(c)};
    return c[2] ? (32'd0 - m) : m;
  endfunction
endpackage

// File: rtl/dma_ch_addr_step.sv
module dma_ch_addr_step #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic [31:0]   delta_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (step_i) addr_q <= addr_q + AW'($signed(delta_i));
  end

  assign addr_o = addr_q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> addr_q == $past(addr_q) + AW'($signed($past(delta_i))));
endmodule

// File: rtl/dma_ch_cycle_cnt.sv
module dma_ch_cycle_cnt #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CW'(1));

  assert_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NL = 16,
  localparam int LW = $clog2(NL),
  localparam int BW = $clog2(BURST_BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          burst_i,
  input  logic [1:0]    width_i,
  input  logic [2:0]    sstep_i,
  input  logic [2:0]    dstep_i,
  input  logic [LW-1:0] sline_i,
  input  logic [LW-1:0] dline_i,
  input  logic          smem_i,
  input  logic          dmem_i,
  input  logic          cnt_zero_i,
  input  logic          cnt_last_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [NL-1:0] dreq_i,
  output logic [NL-1:0] dack_o,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  output logic [AW-1:0] rd_req_addr_o,
  output logic          rd_req_mem_o,
  output logic [1:0]    rd_req_size_o,
  input  logic          rd_rsp_valid_i,
  output logic          rd_rsp_ready_o,
  input  logic [DW-1:0] rd_rsp_data_i,
  output logic          wr_req_valid_o,
  input  logic          wr_req_ready_i,
  output logic [AW-1:0] wr_req_addr_o,
  output logic          wr_req_mem_o,
  output logic [1:0]    wr_req_size_o,
  output logic [DW-1:0] wr_req_data_o,
  output logic          step_o,
  output logic [31:0]   src_delta_o,
  output logic [31:0]   dst_delta_o,
  output logic          dec_o,
  output logic          fin_set_o,
  output logic          err_set_o
);
  seq_state_t    state_q;
  logic [BW-1:0] beat_q;
  logic [DW-1:0] data_q;
  logic          cfg_good, lines_rdy, last_beat, wr_fire;

  assign cfg_good  = cfg_ok(width_i, sstep_i, dstep_i);
  assign lines_rdy = ((sline_i == '0) || dreq_i[sline_i]) &&
                     ((dline_i == '0) || dreq_i[dline_i]);
  assign last_beat = !burst_i || (beat_q == BW'(BURST_BEATS - 1));
  assign wr_fire   = wr_req_valid_o && wr_req_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      data_q  <= '0;
    end else if (!en_i) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (cfg_good && !cnt_zero_i) state_q <= S_WAIT;
        S_WAIT: if (lines_rdy) begin
          state_q <= S_RD;
          beat_q  <= '0;
        end
        S_RD:   if (rd_req_ready_i) state_q <= S_RSP;
        S_RSP:  if (rd_rsp_valid_i) begin
          data_q  <= rd_rsp_data_i;
          state_q <= S_WR;
        end
        S_WR:   if (wr_req_ready_i) begin
          if (last_beat) state_q <= S_ACK;
          else begin
            beat_q  <= beat_q + 1'b1;
            state_q <= S_RD;
          end
        end
        S_ACK:  state_q <= cnt_last_i ? S_IDLE : S_WAIT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_valid_o = en_i && (state_q == S_RD);
  assign rd_req_addr_o  = src_addr_i;
  assign rd_req_mem_o   = smem_i;
  assign rd_req_size_o  = width_i;
  assign rd_rsp_ready_o = (state_q == S_RSP) || (state_q == S_IDLE);
  assign wr_req_valid_o = en_i && (state_q == S_WR);
  assign wr_req_addr_o  = dst_addr_i;
  assign wr_req_mem_o   = dmem_i;
  assign wr_req_size_o  = width_i;
  assign wr_req_data_o  = data_q;

  assign step_o      = wr_fire;
  assign src_delta_o = step_delta(sstep_i);
  assign dst_delta_o = step_delta(dstep_i);
  assign dec_o       = en_i && (state_q == S_ACK);
  assign fin_set_o   = en_i && (((state_q == S_IDLE) && cfg_good && cnt_zero_i) ||
                                ((state_q == S_ACK) && cnt_last_i));
  assign err_set_o   = en_i && (state_q == S_IDLE) && !cfg_good;

  always_comb begin
    dack_o = '0;
    if (en_i && state_q == S_ACK) begin
      if (sline_i != '0) dack_o[sline_i] = 1'b1;
      if (dline_i != '0) dack_o[dline_i] = 1'b1;
    end
  end

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid_o && wr_req_valid_o));
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o || !en_i));
  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid_o && !wr_req_ready_i) |=> ((wr_req_valid_o && $stable(wr_req_data_o)) || !en_i));
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_o |=> (!rd_req_valid_o && !wr_req_valid_o));
  assert_dack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dack_o) <= 2);
endmodule

// File: rtl/dma_ch_top.sv
module dma_ch_top
  import dma_ch_pkg::*;
#(
  parameter int CH_INDEX = 0,
  parameter int RA_W     = 6,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CW       = 24,
  parameter int NL       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_en,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  output logic            rd_req_mem,
  output logic [1:0]      rd_req_size,
  input  logic            rd_rsp_valid,
  output logic            rd_rsp_ready,
  input  logic [DW-1:0]   rd_rsp_data,
  output logic            wr_req_valid,
  input  logic            wr_req_ready,
  output logic [AW-1:0]   wr_req_addr,
  output logic            wr_req_mem,
  output logic [1:0]      wr_req_size,
  output logic [DW-1:0]   wr_req_data,
  input  logic [NL-1:0]   dreq,
  output logic [NL-1:0]   dack,
  output logic            irq
);
  localparam int LW    = $clog2(NL);
  localparam int WIN_W = RA_W - 4;

  logic [31:0]   ctrl_q, ctrl_sw, ctrl_d;
  logic          hit, ctrl_wr, running;
  logic [1:0]    off;
  logic [AW-1:0] side_addr [2];
  logic [31:0]   side_delta[2];
  logic          side_load [2];
  logic [CW-1:0] cnt;
  logic          cnt_zero, cnt_last, cnt_load;
  logic          step, dec, fin_set, err_set;

  assign hit     = reg_en && (reg_addr[RA_W-1:4] == WIN_W'(CH_INDEX)) &&
                   (reg_addr[1:0] == 2'b00);
  assign off     = reg_addr[3:2];
  assign running = ctrl_q[B_EN];
  assign ctrl_wr = hit && reg_wr && (off == 2'd3);

  always_comb begin
    ctrl_sw = ctrl_q;
    if (ctrl_wr) begin
      if (!running) ctrl_sw = reg_wdata & CTRL_KEEP;
      else begin
        ctrl_sw[B_EN]  = reg_wdata[B_EN];
        ctrl_sw[B_FIE] = reg_wdata[B_FIE];
        ctrl_sw[B_EIE] = reg_wdata[B_EIE];
      end
      ctrl_sw[B_FIN] = ctrl_q[B_FIN] & reg_wdata[B_FIN];
      ctrl_sw[B_ERR] = ctrl_q[B_ERR] & reg_wdata[B_ERR];
    end
    ctrl_d = ctrl_sw;
    if (fin_set) begin
      ctrl_d[B_EN]  = 1'b0;
      ctrl_d[B_FIN] = 1'b1;
    end
    if (err_set) begin
      ctrl_d[B_EN]  = 1'b0;
      ctrl_d[B_ERR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign side_delta[0] = 32'd0;
  assign side_delta[1] = 32'd0;

  logic [31:0] src_delta, dst_delta;

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign side_load[s] = hit && reg_wr && !running && (off == 2'(s));
    dma_ch_addr_step #(.AW(AW)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (side_load[s]),
      .load_val_i(reg_wdata[AW-1:0]),
      .step_i    (step),
      .delta_i   ((s == 0) ? src_delta : dst_delta),
      .addr_o    (side_addr[s])
    );
  end

  assign cnt_load = hit && reg_wr && !running && (off == 2'd2);

  dma_ch_cycle_cnt #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cnt_load),
    .load_val_i(reg_wdata[CW-1:0]),
    .dec_i     (dec),
    .cnt_o     (cnt),
    .zero_o    (cnt_zero),
    .last_o    (cnt_last)
  );

  dma_ch_seq #(.AW(AW), .DW(DW), .NL(NL)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (running),
    .burst_i       (ctrl_q[B_BURST]),
    .width_i       (ctrl_q[F_WID +: 2]),
    .sstep_i       (ctrl_q[F_SSTEP +: 3]),
    .dstep_i       (ctrl_q[F_DSTEP +: 3]),
    .sline_i       (ctrl_q[F_SLINE +: LW]),
    .dline_i       (ctrl_q[F_DLINE +: LW]),
    .smem_i        (ctrl_q[B_SMEM]),
    .dmem_i        (ctrl_q[B_DMEM]),
    .cnt_zero_i    (cnt_zero),
    .cnt_last_i    (cnt_last),
    .src_addr_i    (side_addr[0]),
    .dst_addr_i    (side_addr[1]),
    .dreq_i        (dreq),
    .dack_o        (dack),
    .rd_req_valid_o(rd_req_valid),
    .rd_req_ready_i(rd_req_ready),
    .rd_req_addr_o (rd_req_addr),
    .rd_req_mem_o  (rd_req_mem),
    .rd_req_size_o (rd_req_size),
    .rd_rsp_valid_i(rd_rsp_valid),
    .rd_rsp_ready_o(rd_rsp_ready),
    .rd_rsp_data_i (rd_rsp_data),
    .wr_req_valid_o(wr_req_valid),
    .wr_req_ready_i(wr_req_ready),
    .wr_req_addr_o (wr_req_addr),
    .wr_req_mem_o  (wr_req_mem),
    .wr_req_size_o (wr_req_size),
    .wr_req_data_o (wr_req_data),
    .step_o        (step),
    .src_delta_o   (src_delta),
    .dst_delta_o   (dst_delta),
    .dec_o         (dec),
    .fin_set_o     (fin_set),
    .err_set_o     (err_set)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (off)
        2'd0:    reg_rdata = 32'(side_addr[0]);
        2'd1:    reg_rdata = 32'(side_addr[1]);
        2'd2:    reg_rdata = 32'(cnt);
        default: reg_rdata = ctrl_q;
      endcase
    end
  end

  assign irq = (ctrl_q[B_FIN] && ctrl_q[B_FIE]) || (ctrl_q[B_ERR] && ctrl_q[B_EIE]);

  assert_fin_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_set |=> (!ctrl_q[B_EN] && ctrl_q[B_FIN]));
  assert_cnt_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hit && reg_wr && off == 2'd2 && !dec) |=> cnt == $past(cnt));
  assert_src_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hit && reg_wr && off == 2'd0 && !step) |=> side_addr[0] == $past(side_addr[0]));
endmodule

// File: tb/dma_ch_top_tb_top.sv
module dma_ch_top_tb_top;
  localparam int RA_W = 6;
  localparam int NL   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_en = 1'b0, reg_wr = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0, reg_rdata;
  logic            rd_req_valid, rd_req_ready, rd_req_mem, rd_rsp_valid, rd_rsp_ready;
  logic [31:0]     rd_req_addr, rd_rsp_data, wr_req_addr, wr_req_data;
  logic [1:0]      rd_req_size, wr_req_size;
  logic            wr_req_valid, wr_req_ready, wr_req_mem;
  logic [NL-1:0]   dreq = '0, dack;
  logic            irq;

  int n_chk = 0, n_fail = 0;
  logic        rsp_pend, cyc, wr_gate = 1'b1;
  logic [31:0] rsp_dat;
  int n_rd, n_wr, dack3_n, dack5_n, dack_oth_n;
  logic [31:0] wa[64], wd[64];
  logic        wm[64];
  logic [1:0]  ws[64];
  logic        finished = 1'b0;

  always #4 clk = ~clk;

  dma_ch_top #(.CH_INDEX(2), .RA_W(RA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_mem(rd_req_mem), .rd_req_size(rd_req_size),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .wr_req_mem(wr_req_mem), .wr_req_size(wr_req_size), .wr_req_data(wr_req_data),
    .dreq(dreq), .dack(dack), .irq(irq));

  assign rd_req_ready = 1'b1;
  assign rd_rsp_valid = rsp_pend;
  assign rd_rsp_data  = rsp_dat;
  assign wr_req_ready = wr_gate | cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_pend <= 1'b0; rsp_dat <= '0; cyc <= 1'b0;
      n_rd <= 0; n_wr <= 0; dack3_n <= 0; dack5_n <= 0; dack_oth_n <= 0;
    end else begin
      cyc <= ~cyc;
      if (rd_req_valid && rd_req_ready) begin
        rsp_pend <= 1'b1;
        rsp_dat  <= {rd_req_mem ? 8'hA0 : 8'h50, rd_req_addr[23:0]};
        n_rd     <= n_rd + 1;
      end else if (rsp_pend && rd_rsp_ready) rsp_pend <= 1'b0;
      if (wr_req_valid && wr_req_ready) begin
        if (n_wr < 64) begin
          wa[n_wr] <= wr_req_addr; wd[n_wr] <= wr_req_data;
          wm[n_wr] <= wr_req_mem;  ws[n_wr] <= wr_req_size;
        end
        n_wr <= n_wr + 1;
      end
      if (dack[3]) dack3_n <= dack3_n + 1;
      if (dack[5]) dack5_n <= dack5_n + 1;
      if ((dack & ~16'h0028) != '0) dack_oth_n <= dack_oth_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [RA_W-1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [RA_W-1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    int g = 0;
    do begin rd_reg(6'h2C, v); g++; end while (v[0] && g < 5000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(6'h2C, v); chk("R1 ctrl after reset", v, 32'h0);
    rd_reg(6'h28, v); chk("R1 count after reset", v, 32'h0);
    rd_reg(6'h20, v); chk("R1 src after reset", v, 32'h0);
    chk("R1 irq/requests idle", {30'd0, irq, rd_req_valid | wr_req_valid}, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int b = n_wr, r = n_rd;
    wr_gate = 1'b0;
    wr_reg(6'h20, 32'h1000); wr_reg(6'h24, 32'h2000); wr_reg(6'h28, 32'd3);
    wr_reg(6'h2C, 32'h0000_33C5);
    wait_done();
    chk("R3 read count", n_rd - r, 3);
    chk("R3 write count", n_wr - b, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R4 dst address +4", wa[b+k], 32'h2000 + 4*k);
      chk("R3 data from source", wd[b+k], 32'hA000_1000 + 4*k);
      chk("R3/R5 mem bus, word size", {29'd0, wm[b+k], ws[b+k]}, 32'h4);
    end
    rd_reg(6'h28, v); chk("R6 count zero", v, 0);
    rd_reg(6'h2C, v); chk("R6 enable off, finish on", v, 32'h0000_33C6);
    rd_reg(6'h20, v); chk("R4 final src", v, 32'h100C);
    chk("R7 irq on finish", {31'd0, irq}, 1);
    wr_gate = 1'b1;
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr_reg(6'h2C, 32'h0000_33C4);
    rd_reg(6'h2C, v); chk("R8 finish cleared", v, 32'h0000_33C4);
    chk("R7 irq drops", {31'd0, irq}, 0);
    wr_reg(6'h2C, 32'h0000_33D6);
    rd_reg(6'h2C, v); chk("R8 writing 1 does not set", v, 32'h0000_33C4);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    int b = n_wr;
    wr_reg(6'h20, 32'h3010); wr_reg(6'h24, 32'h4000); wr_reg(6'h28, 32'd2);
    wr_reg(6'h2C, 32'h0020_0589);
    wait_done();
    chk("R4 burst beats", n_wr - b, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R4 dst held", wa[b+k], 32'h4000);
      chk("R4 src -1 peripheral data", wd[b+k], 32'h5000_3010 - k);
      chk("R5 byte size, R3 dst mem", {29'd0, wm[b+k], ws[b+k]}, 32'h6);
    end
    rd_reg(6'h20, v); chk("R4 src after burst", v, 32'h3008);
    rd_reg(6'h2C, v); chk("R6 burst finish", v, 32'h0020_058A);
    chk("R7 no irq when finish irq disabled", {31'd0, irq}, 0);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    int b = n_wr, r = n_rd, d0 = dack3_n;
    wr_reg(6'h2C, 32'h0);
    wr_reg(6'h20, 32'h100); wr_reg(6'h24, 32'h200); wr_reg(6'h28, 32'd2);
    wr_reg(6'h2C, 32'h0300_33C1);
    repeat (20) @(negedge clk);
    chk("R9 waits for request", n_rd - r, 0);
    dreq[3] = 1'b1;
    for (int g = 0; g < 200 && dack3_n - d0 < 1; g++) @(negedge clk);
    dreq[3] = 1'b0;
    repeat (20) @(negedge clk);
    rd_reg(6'h28, v); chk("R6 remaining count mid-transfer", v, 1);
    chk("R9 one unit per request", n_wr - b, 1);
    dreq[3] = 1'b1;
    wait_done();
    dreq[3] = 1'b0;
    chk("R9 grant pulses", dack3_n - d0, 2);
    chk("R9 no other grants", dack_oth_n, 0);
    chk("R3 handshake data", wd[b+1], 32'hA000_0104);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int r = n_rd;
    wr_reg(6'h2C, 32'h0);
    wr_reg(6'h28, 32'd4);
    wr_reg(6'h2C, 32'h0010_0321);
    repeat (5) @(negedge clk);
    rd_reg(6'h2C, v); chk("R10 step/width mismatch error", v, 32'h0010_0330);
    chk("R7 irq on error", {31'd0, irq}, 1);
    wr_reg(6'h2C, 32'h0030_0021);
    repeat (5) @(negedge clk);
    rd_reg(6'h2C, v); chk("R10 width code 11 error", v, 32'h0030_0030);
    chk("R10 no reads on error", n_rd - r, 0);
    wr_reg(6'h2C, 32'h0);
    chk("R8 error cleared irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int b = n_wr, d0 = dack5_n;
    wr_reg(6'h20, 32'h500); wr_reg(6'h24, 32'h600); wr_reg(6'h28, 32'd10);
    wr_reg(6'h2C, 32'h0005_33C1);
    repeat (5) @(negedge clk);
    wr_reg(6'h28, 32'd7);
    rd_reg(6'h28, v); chk("R12 count locked", v, 10);
    wr_reg(6'h20, 32'hFFF0);
    rd_reg(6'h20, v); chk("R12 src locked", v, 32'h500);
    wr_reg(6'h0C, 32'h0);
    rd_reg(6'h2C, v); chk("R2 other window ignored", {31'd0, v[0]}, 1);
    wr_reg(6'h2C, 32'h0005_33C0);
    dreq[5] = 1'b1;
    repeat (20) @(negedge clk);
    dreq[5] = 1'b0;
    chk("R11 no writes after abort", n_wr - b, 0);
    chk("R11 no grant after abort", dack5_n - d0, 0);
    rd_reg(6'h2C, v); chk("R11 stopped, no finish", v, 32'h0005_33C0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_clear();
    t_burst();
    t_handshake();
    t_error();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule